// File: doc/BRIEF.md
# Multi-Master Banked SRAM Crossbar

This block connects four bus masters to four on-chip SRAM banks. Master 0 is the CPU data port, master 1 is the CPU instruction/system port, and masters 2 and 3 are DMA-style engines such as a network controller and a USB controller. Every request carries an address, a write flag, an access size and write data. A per-master decoder resolves the address to one bank, or flags it as an error. A per-bank fixed-priority arbiter picks one master for each bank.

Masters that address different banks are all served in the same cycle. A master that loses a bank conflict sees `wait` high, holds its request, and is served once the bank is free. Accepted accesses complete with zero wait states: a response (`rvalid` or `rerr`) comes on the cycle after acceptance. Three general banks sit near `G0_BASE`. A private core-coupled bank sits at `CCM_BASE` and answers only the CPU data port. When `remap` is set, the CPU ports also see the general banks at address zero.

Each bank stores `MEM_WORDS` words. The decoded region of a bank can be larger than its storage, and the storage index is the word offset taken modulo `MEM_WORDS`.

Each master port has a response state machine with three states:
- RSP_IDLE: no response this cycle.
- RSP_DATA: a successful response; read data is returned.
- RSP_FAULT: an error response.

Every cycle the machine moves to RSP_FAULT if the previous cycle held an error request. It moves to RSP_DATA if the previous cycle held an accepted request. Otherwise it returns to RSP_IDLE. Any state can reach any state in one step.

Top module: `sram_xbar`

## Requirements
- R1: Size code 0 is a byte on lane addr[1:0]. Code 1 is a half-word on lanes 1:0 when addr[1]=0, or lanes 3:2 when addr[1]=1. Codes 2 and 3 are a full word. Write data is taken lane-positioned from `wdata`, and lanes outside the access keep their contents. A read returns the whole 32-bit word.
- R2: An accepted request (req high, wait low) gets exactly one of `rvalid` or `rerr` on the next cycle, and no response otherwise. A read's `rdata` is the addressed word, including writes accepted in earlier cycles.
- R3: General bank A spans `G0_BASE` (0x2000_0000) for `BANK0_KB` (112 KB). Bank B follows directly for `BANK1_KB` (16 KB). Bank C spans `G2_BASE` (0x2002_0000) for `BANK2_KB` (64 KB). All masters may use these banks.
- R4: The core-coupled bank spans `CCM_BASE` (0x1000_0000) for `CCM_KB` (64 KB) and serves only master 0. A request to it from masters 1 to 3 gets `rerr` on the next cycle and leaves the bank unchanged.
- R5: Masters that address different banks in the same cycle all see wait low and are all served in that cycle.
- R6: With `remap` set, addresses of masters 0 and 1 below `G2_BASE-G0_BASE+BANK2_KB*1024` (0x0003_0000 by default) are offset by `G0_BASE`. Masters 2 and 3 are not remapped. With `remap` clear, address 0 is unmapped.
- R7: When several masters address one bank in the same cycle, the lowest master index wins and the others see wait high. Wait is high only while that master's req is high, and master 0 never waits.
- R8: An address outside every bank gets `rerr` on the next cycle, never causes a wait, and writes no bank.
- R9: A write response has `rvalid` high and `rdata` zero. `rdata` is zero in every cycle without a read response.
- R10: While reset is asserted, and in the first cycle after it, `rvalid` and `rerr` are low on all masters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| remap | input | 1 | Alias general banks at address zero for CPU ports |
| m_req | input | 4 | Request valid, one bit per master |
| m_we | input | 4 | Write flag per master |
| m_addr | input | 128 | Byte address, 32 bits per master |
| m_size | input | 8 | Access size code, 2 bits per master |
| m_wdata | input | 128 | Lane-positioned write data, 32 bits per master |
| m_wait | output | 4 | Request stalled by a bank conflict |
| m_rvalid | output | 4 | Successful response, one cycle after acceptance |
| m_rerr | output | 4 | Error response, one cycle after the request |
| m_rdata | output | 128 | Read data, 32 bits per master |

## Verification
The two functions that can fall in the same cycle are concurrent service of different banks and fixed-priority arbitration on a shared bank. A decode error can also arrive beside a conflict in that same cycle. The bench provokes these cases by driving two or three masters on the same falling edge. The targets include separate banks, one shared bank, and a shared bank combined with a foreign access to the core-coupled bank. The bench judges each case at the `wait` outputs against the expected winner. It also checks through a scoreboard that every accepted access returns in the following cycle with the data from a reference memory model, which shows that the losing or faulting request neither corrupted nor delayed the others.

// File: rtl/sram_xbar_pkg.sv
package sram_xbar_pkg;
    localparam int NUM_M = 4;
    localparam int NUM_B = 4;
    localparam int AW    = 32;
    localparam int DW    = 32;
    localparam int BEW   = DW / 8;
    localparam int BIDW  = $clog2(NUM_B);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef enum logic [1:0] {
        RSP_IDLE  = 2'd0,
        RSP_DATA  = 2'd1,
        RSP_FAULT = 2'd2
    } rsp_state_e;
endpackage

// File: rtl/sram_route_dec.sv
module sram_route_dec
    import sram_xbar_pkg::*;
#(
    parameter int          MIDX      = 0,
    parameter logic [31:0] G0_BASE   = 32'h2000_0000,
    parameter logic [31:0] G2_BASE   = 32'h2002_0000,
    parameter logic [31:0] CCM_BASE  = 32'h1000_0000,
    parameter logic [31:0] B0_BYTES  = 32'd114688,
    parameter logic [31:0] B1_BYTES  = 32'd16384,
    parameter logic [31:0] B2_BYTES  = 32'd65536,
    parameter logic [31:0] B3_BYTES  = 32'd65536,
    parameter int          IW        = 8
) (
    input  logic            req,
    input  logic            remap,
    input  logic [AW-1:0]   addr,
    input  logic [1:0]      size,
    output logic            hit,
    output logic            fault,
    output logic [BIDW-1:0] bank,
    output logic [IW-1:0]   idx,
    output logic [BEW-1:0]  be
);
    localparam logic [AW-1:0] G0_END     = G0_BASE + B0_BYTES;
    localparam logic [AW-1:0] G1_BASE    = G0_END;
    localparam logic [AW-1:0] G1_END     = G1_BASE + B1_BYTES;
    localparam logic [AW-1:0] G2_END     = G2_BASE + B2_BYTES;
    localparam logic [AW-1:0] CCM_END    = CCM_BASE + B3_BYTES;
    localparam logic [AW-1:0] ALIAS_SPAN = G2_END - G0_BASE;
    localparam bit            CAN_REMAP  = (MIDX < 2);
    localparam bit            CAN_CCM    = (MIDX == 0);

    logic [AW-1:0] eff;
    logic [AW-1:0] offset;

    always_comb begin
        eff = addr;
        if (CAN_REMAP && remap && (addr < ALIAS_SPAN)) begin
            eff = addr + G0_BASE;
        end
        hit    = 1'b0;
        fault  = 1'b0;
        bank   = '0;
        offset = '0;
        if (req) begin
            if (eff >= G0_BASE && eff < G0_END) begin
                hit    = 1'b1;
                bank   = BIDW'(0);
                offset = eff - G0_BASE;
            end else if (eff >= G1_BASE && eff < G1_END) begin
                hit    = 1'b1;
                bank   = BIDW'(1);
                offset = eff - G1_BASE;
            end else if (eff >= G2_BASE && eff < G2_END) begin
                hit    = 1'b1;
                bank   = BIDW'(2);
                offset = eff - G2_BASE;
            end else if (CAN_CCM && eff >= CCM_BASE && eff < CCM_END) begin
                hit    = 1'b1;
                bank   = BIDW'(3);
                offset = eff - CCM_BASE;
            end else begin
                fault  = 1'b1;
            end
        end
        idx = IW'(offset >> 2);
    end

    always_comb begin
        unique case (acc_size_e'(size))
            SZ_BYTE: be = BEW'(1) << addr[1:0];
            SZ_HALF: be = addr[1] ? 4'b1100 : 4'b0011;
            default: be = '1;
        endcase
    end
endmodule

// File: rtl/sram_bank_arb.sv
module sram_bank_arb
    import sram_xbar_pkg::*;
#(
    parameter int BIDX = 0
) (
    input  logic [NUM_M-1:0]      hit,
    input  logic [NUM_M*BIDW-1:0] tgt,
    output logic [NUM_M-1:0]      gnt
);
    logic taken;

    always_comb begin
        gnt   = '0;
        taken = 1'b0;
        for (int m = 0; m < NUM_M; m++) begin
            if (!taken && hit[m] && (tgt[m*BIDW +: BIDW] == BIDW'(BIDX))) begin
                gnt[m] = 1'b1;
                taken  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sram_bank.sv
module sram_bank
    import sram_xbar_pkg::*;
#(
    parameter int MEM_WORDS = 256,
    parameter int IW        = $clog2(MEM_WORDS)
) (
    input  logic           clk,
    input  logic           en,
    input  logic           we,
    input  logic [BEW-1:0] be,
    input  logic [IW-1:0]  idx,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata
);
    logic [DW-1:0] mem [MEM_WORDS];

    always_ff @(posedge clk) begin
        if (en && we) begin
            for (int l = 0; l < BEW; l++) begin
                if (be[l]) begin
                    mem[idx][l*8 +: 8] <= wdata[l*8 +: 8];
                end
            end
        end
        if (en && !we) begin
            rdata <= mem[idx];
        end
    end
endmodule

// File: rtl/sram_rsp_port.sv
module sram_rsp_port
    import sram_xbar_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept,
    input  logic                fault,
    input  logic                we,
    input  logic [BIDW-1:0]     bank,
    input  logic [NUM_B*DW-1:0] bank_rdata,
    output logic                rvalid,
    output logic                rerr,
    output logic [DW-1:0]       rdata
);
    rsp_state_e      state_q, state_d;
    logic [BIDW-1:0] bank_q;
    logic            rd_q;

    always_comb begin
        state_d = RSP_IDLE;
        if (fault) begin
            state_d = RSP_FAULT;
        end else if (accept) begin
            state_d = RSP_DATA;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
            bank_q  <= '0;
            rd_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                bank_q <= bank;
                rd_q   <= !we;
            end
        end
    end

    always_comb begin
        rvalid = 1'b0;
        rerr   = 1'b0;
        rdata  = '0;
        unique case (state_q)
            RSP_IDLE: ;
            RSP_DATA: begin
                rvalid = 1'b1;
                if (rd_q) begin
                    rdata = bank_rdata[bank_q*DW +: DW];
                end
            end
            RSP_FAULT: rerr = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/sram_xbar.sv
module sram_xbar
    import sram_xbar_pkg::*;
#(
    parameter logic [31:0] G0_BASE   = 32'h2000_0000,
    parameter logic [31:0] G2_BASE   = 32'h2002_0000,
    parameter logic [31:0] CCM_BASE  = 32'h1000_0000,
    parameter int          BANK0_KB  = 112,
    parameter int          BANK1_KB  = 16,
    parameter int          BANK2_KB  = 64,
    parameter int          CCM_KB    = 64,
    parameter int          MEM_WORDS = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                remap,
    input  logic [NUM_M-1:0]    m_req,
    input  logic [NUM_M-1:0]    m_we,
    input  logic [NUM_M*AW-1:0] m_addr,
    input  logic [NUM_M*2-1:0]  m_size,
    input  logic [NUM_M*DW-1:0] m_wdata,
    output logic [NUM_M-1:0]    m_wait,
    output logic [NUM_M-1:0]    m_rvalid,
    output logic [NUM_M-1:0]    m_rerr,
    output logic [NUM_M*DW-1:0] m_rdata
);
    localparam int          IW = $clog2(MEM_WORDS);
    localparam logic [31:0] B0 = 32'(BANK0_KB * 1024);
    localparam logic [31:0] B1 = 32'(BANK1_KB * 1024);
    localparam logic [31:0] B2 = 32'(BANK2_KB * 1024);
    localparam logic [31:0] B3 = 32'(CCM_KB * 1024);

    logic [NUM_M-1:0]      hit, fault, granted;
    logic [NUM_M*BIDW-1:0] tgt_flat;
    logic [IW-1:0]         idx [NUM_M];
    logic [BEW-1:0]        be  [NUM_M];
    logic [NUM_M-1:0]      gnt [NUM_B];
    logic [NUM_B*NUM_M-1:0] gnt_flat;
    logic [NUM_B*DW-1:0]   bank_rdata_flat;

    for (genvar m = 0; m < NUM_M; m++) begin : g_master
        sram_route_dec #(
            .MIDX(m), .G0_BASE(G0_BASE), .G2_BASE(G2_BASE), .CCM_BASE(CCM_BASE),
            .B0_BYTES(B0), .B1_BYTES(B1), .B2_BYTES(B2), .B3_BYTES(B3), .IW(IW)
        ) u_dec (
            .req   (m_req[m]),
            .remap (remap),
            .addr  (m_addr[m*AW +: AW]),
            .size  (m_size[m*2 +: 2]),
            .hit   (hit[m]),
            .fault (fault[m]),
            .bank  (tgt_flat[m*BIDW +: BIDW]),
            .idx   (idx[m]),
            .be    (be[m])
        );

        sram_rsp_port u_rsp (
            .clk        (clk),
            .rst_n      (rst_n),
            .accept     (granted[m]),
            .fault      (fault[m]),
            .we         (m_we[m]),
            .bank       (tgt_flat[m*BIDW +: BIDW]),
            .bank_rdata (bank_rdata_flat),
            .rvalid     (m_rvalid[m]),
            .rerr       (m_rerr[m]),
            .rdata      (m_rdata[m*DW +: DW])
        );
    end

    for (genvar b = 0; b < NUM_B; b++) begin : g_bank
        logic           en, we;
        logic [BEW-1:0] bbe;
        logic [IW-1:0]  bidx;
        logic [DW-1:0]  bwd;

        sram_bank_arb #(.BIDX(b)) u_arb (
            .hit (hit),
            .tgt (tgt_flat),
            .gnt (gnt[b])
        );

        always_comb begin
            en   = 1'b0;
            we   = 1'b0;
            bbe  = '0;
            bidx = '0;
            bwd  = '0;
            for (int m = 0; m < NUM_M; m++) begin
                if (gnt[b][m]) begin
                    en   = 1'b1;
                    we   = m_we[m];
                    bbe  = be[m];
                    bidx = idx[m];
                    bwd  = m_wdata[m*DW +: DW];
                end
            end
        end

        sram_bank #(.MEM_WORDS(MEM_WORDS), .IW(IW)) u_mem (
            .clk   (clk),
            .en    (en),
            .we    (we),
            .be    (bbe),
            .idx   (bidx),
            .wdata (bwd),
            .rdata (bank_rdata_flat[b*DW +: DW])
        );

        assign gnt_flat[b*NUM_M +: NUM_M] = gnt[b];
    end

    always_comb begin
        granted = '0;
        for (int b = 0; b < NUM_B; b++) begin
            granted = granted | gnt[b];
        end
    end

    assign m_wait = hit & ~granted;
endmodule

// File: rtl/sram_xbar_chk.sv
module sram_xbar_chk
    import sram_xbar_pkg::*;
#(
    parameter logic [31:0] CCM_BASE  = 32'h1000_0000,
    parameter logic [31:0] CCM_BYTES = 32'd65536
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_M-1:0]       m_req,
    input logic [NUM_M*AW-1:0]    m_addr,
    input logic [NUM_M-1:0]       m_wait,
    input logic [NUM_M-1:0]       m_rvalid,
    input logic [NUM_M-1:0]       m_rerr,
    input logic [NUM_B*NUM_M-1:0] bank_gnt
);
    localparam logic [31:0] CCM_END = CCM_BASE + CCM_BYTES;

    for (genvar b = 0; b < NUM_B; b++) begin : g_bank_chk
        AST_BANK_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(bank_gnt[b*NUM_M +: NUM_M])); // R7
    end

    for (genvar m = 0; m < NUM_M; m++) begin : g_port_chk
        AST_WAIT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            m_wait[m] |-> m_req[m]); // R7
        AST_ACCEPT_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
            (m_req[m] && !m_wait[m]) |=> (m_rvalid[m] ^ m_rerr[m])); // R2
        AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            !(m_req[m] && !m_wait[m]) |=> !(m_rvalid[m] || m_rerr[m])); // R2
        if (m > 0) begin : g_foreign
            AST_CCM_FOREIGN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
                (m_req[m] && m_addr[m*AW +: AW] >= CCM_BASE && m_addr[m*AW +: AW] < CCM_END)
                |=> m_rerr[m]); // R4
        end
    end

    AST_CPU_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        !m_wait[0]); // R7
endmodule

bind sram_xbar sram_xbar_chk #(
    .CCM_BASE  (CCM_BASE),
    .CCM_BYTES (32'(CCM_KB * 1024))
) u_sram_xbar_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .m_req    (m_req),
    .m_addr   (m_addr),
    .m_wait   (m_wait),
    .m_rvalid (m_rvalid),
    .m_rerr   (m_rerr),
    .bank_gnt (gnt_flat)
);

// File: tb/test_sram_xbar.sv
`timescale 1ns/1ps
module test_sram_xbar;
    import sram_xbar_pkg::*;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                remap = 1'b0;
    logic [NUM_M-1:0]    m_req = '0;
    logic [NUM_M-1:0]    m_we = '0;
    logic [NUM_M*AW-1:0] m_addr = '0;
    logic [NUM_M*2-1:0]  m_size = '0;
    logic [NUM_M*DW-1:0] m_wdata = '0;
    logic [NUM_M-1:0]    m_wait, m_rvalid, m_rerr;
    logic [NUM_M*DW-1:0] m_rdata;

    always #2 clk = ~clk;

    sram_xbar i_sram_xbar (
        .clk(clk), .rst_n(rst_n), .remap(remap), .m_req(m_req), .m_we(m_we),
        .m_addr(m_addr), .m_size(m_size), .m_wdata(m_wdata), .m_wait(m_wait),
        .m_rvalid(m_rvalid), .m_rerr(m_rerr), .m_rdata(m_rdata)
    );

    typedef struct {
        bit          err;
        logic [31:0] data;
        int          due;
        string       tag;
    } exp_t;

    exp_t        sbq [NUM_M][$];
    logic [31:0] ref_mem [int unsigned];
    int          cyc = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    function automatic bit map_addr(input int m, input logic [31:0] a, output logic [31:0] pa);
        pa = a;
        if (remap && m < 2 && a < 32'h0003_0000) pa = a + 32'h2000_0000;
        if (pa >= 32'h2000_0000 && pa < 32'h2003_0000) return 1'b1;
        if (m == 0 && pa >= 32'h1000_0000 && pa < 32'h1001_0000) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [3:0] lanes(input logic [31:0] a, input logic [1:0] sz);
        case (sz)
            2'd0:    return 4'b0001 << a[1:0];
            2'd1:    return a[1] ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    task automatic drive(input int m, input bit we, input logic [31:0] a,
                         input logic [1:0] sz, input logic [31:0] wd);
        m_req[m]            = 1'b1;
        m_we[m]             = we;
        m_addr[m*AW +: AW]  = a;
        m_size[m*2 +: 2]    = sz;
        m_wdata[m*DW +: DW] = wd;
    endtask

    // Scoreboard driver: checks waits, pushes expected items, retires accepted requests
    task automatic step(input logic [3:0] exp_wait, input string req);
        logic [3:0] accepted;
        #1;
        accepted = '0;
        for (int m = 0; m < NUM_M; m++) begin
            if (m_req[m]) begin
                exp_t        e;
                logic [31:0] pa, a, wd, w;
                logic [3:0]  l;
                check(m_wait[m] == exp_wait[m], req, $sformatf("wait m%0d", m),
                      32'(m_wait[m]), 32'(exp_wait[m]));
                if (!m_wait[m]) begin
                    accepted[m] = 1'b1;
                    a  = m_addr[m*AW +: AW];
                    wd = m_wdata[m*DW +: DW];
                    e.due = cyc + 1;
                    e.tag = req;
                    if (!map_addr(m, a, pa)) begin
                        e.err  = 1'b1;
                        e.data = '0;
                    end else if (m_we[m]) begin
                        e.err = 1'b0;
                        e.data = '0;
                        w = ref_mem.exists(pa >> 2) ? ref_mem[pa >> 2] : 32'h0;
                        l = lanes(a, m_size[m*2 +: 2]);
                        for (int k = 0; k < 4; k++) if (l[k]) w[k*8 +: 8] = wd[k*8 +: 8];
                        ref_mem[pa >> 2] = w;
                    end else begin
                        e.err  = 1'b0;
                        e.data = ref_mem.exists(pa >> 2) ? ref_mem[pa >> 2] : 32'h0;
                    end
                    sbq[m].push_back(e);
                end
            end
        end
        @(negedge clk);
        m_req = m_req & ~accepted;
    endtask

    task automatic settle(input string req);
        while (m_req != '0) step(4'b0000, req);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic single(input int m, input bit we, input logic [31:0] a,
                          input logic [1:0] sz, input logic [31:0] wd, input string req);
        drive(m, we, a, sz, wd);
        settle(req);
    endtask

    // Monitor: pops and compares responses
    always @(negedge clk) begin
        if (rst_n) begin
            for (int m = 0; m < NUM_M; m++) begin
                if (m_rvalid[m] || m_rerr[m]) begin
                    if (sbq[m].size() == 0) begin
                        check(1'b0, "R2", $sformatf("unexpected response m%0d", m), 32'(m_rerr[m]), 0);
                    end else begin
                        exp_t e;
                        e = sbq[m].pop_front();
                        check(cyc == e.due, e.tag, $sformatf("resp cycle m%0d", m), cyc, e.due);
                        check(m_rerr[m] == e.err && m_rvalid[m] != m_rerr[m], e.tag,
                              $sformatf("resp kind m%0d", m), 32'(m_rerr[m]), 32'(e.err));
                        check(m_rdata[m*DW +: DW] == e.data, e.tag,
                              $sformatf("rdata m%0d", m), m_rdata[m*DW +: DW], e.data);
                    end
                end else if (sbq[m].size() > 0 && sbq[m][0].due < cyc) begin
                    exp_t e;
                    e = sbq[m].pop_front();
                    check(1'b0, e.tag, $sformatf("missing response m%0d", m), 0, 1);
                end else if (m_rdata[m*DW +: DW] != 0) begin
                    check(1'b0, "R9", $sformatf("idle rdata m%0d", m), m_rdata[m*DW +: DW], 0);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            check(1'b0, "watchdog", "timeout", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: quiet during reset
        check(m_rvalid == 0 && m_rerr == 0, "R10", "reset resp", {24'b0, m_rvalid, m_rerr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(m_rvalid == 0 && m_rerr == 0 && m_wait == 0, "R10", "post-reset",
              {20'b0, m_wait, m_rvalid, m_rerr}, 0);

        // R2, R3: word write/read in bank A
        single(0, 1, 32'h2000_0000, 2'd2, 32'hA5A5_5A5A, "R9");
        single(0, 0, 32'h2000_0000, 2'd2, 0, "R2");

        // R1: byte and half-word lanes
        single(1, 1, 32'h2000_0010, 2'd2, 32'h1122_3344, "R1");
        single(1, 1, 32'h2000_0012, 2'd0, 32'h00AB_0000, "R1");
        single(1, 0, 32'h2000_0010, 2'd2, 0, "R1");
        single(2, 1, 32'h2000_0012, 2'd1, 32'hBEEF_0000, "R1");
        single(2, 1, 32'h2000_0011, 2'd0, 32'h0000_7700, "R1");
        single(3, 0, 32'h2000_0010, 2'd1, 0, "R1");
        single(3, 1, 32'h2000_0020, 2'd3, 32'hCAFE_F00D, "R1");
        single(0, 0, 32'h2000_0020, 2'd0, 0, "R1");

        // R3: bank B and bank C bases
        single(2, 1, 32'h2001_C000, 2'd2, 32'h0B0B_0B0B, "R3");
        single(3, 1, 32'h2002_0000, 2'd2, 32'h0C0C_0C0C, "R3");
        single(2, 0, 32'h2001_C000, 2'd2, 0, "R3");
        single(3, 0, 32'h2002_0000, 2'd2, 0, "R3");
        single(0, 1, 32'h2001_BFFC, 2'd2, 32'h1234_5678, "R3");
        single(1, 0, 32'h2001_BFFC, 2'd2, 0, "R3");

        // R5: three masters on three banks at once
        drive(0, 1, 32'h2000_0040, 2'd2, 32'h5050_0000);
        drive(2, 1, 32'h2002_0040, 2'd2, 32'h5252_0000);
        drive(3, 1, 32'h2001_C040, 2'd2, 32'h5353_0000);
        step(4'b0000, "R5");
        settle("R5");
        drive(1, 0, 32'h2000_0040, 2'd2, 0);
        drive(2, 0, 32'h2001_C040, 2'd2, 0);
        drive(3, 0, 32'h2002_0040, 2'd2, 0);
        step(4'b0000, "R5");
        settle("R5");

        // R7: conflicts on one bank
        drive(2, 1, 32'h2002_0080, 2'd2, 32'h2222_2222);
        drive(3, 1, 32'h2002_0080, 2'd2, 32'h3333_3333);
        step(4'b1000, "R7");
        step(4'b0000, "R7");
        settle("R7");
        single(0, 0, 32'h2002_0080, 2'd2, 0, "R7");
        drive(1, 0, 32'h2000_0000, 2'd2, 0);
        drive(2, 1, 32'h2000_0000, 2'd2, 32'h0000_0001);
        drive(0, 0, 32'h2000_0010, 2'd2, 0);
        step(4'b0110, "R7");
        step(4'b0100, "R7");
        step(4'b0000, "R7");
        settle("R7");

        // R4: core-coupled bank
        single(0, 1, 32'h1000_0004, 2'd2, 32'hC0C0_1234, "R4");
        single(2, 1, 32'h1000_0004, 2'd2, 32'hDEAD_DEAD, "R4");
        single(1, 1, 32'h1000_0004, 2'd2, 32'hDEAD_BEEF, "R4");
        single(0, 0, 32'h1000_0004, 2'd2, 0, "R4");
        // foreign CCM access beside a bank conflict
        drive(0, 0, 32'h2002_0000, 2'd2, 0);
        drive(2, 0, 32'h2002_0000, 2'd2, 0);
        drive(3, 1, 32'h1000_0004, 2'd2, 32'h0);
        step(4'b0100, "R4");
        settle("R4");

        // R6: remap
        remap = 1'b1;
        single(1, 0, 32'h0000_0000, 2'd2, 0, "R6");
        single(0, 1, 32'h0002_0004, 2'd2, 32'h6060_6060, "R6");
        single(3, 0, 32'h2002_0004, 2'd2, 0, "R6");
        single(2, 0, 32'h0000_0000, 2'd2, 0, "R6");
        single(0, 0, 32'h0003_0000, 2'd2, 0, "R6");
        remap = 1'b0;
        single(0, 0, 32'h0000_0000, 2'd2, 0, "R6");

        // R8: unmapped addresses, no write side effect
        single(0, 1, 32'h3000_0000, 2'd2, 32'hFFFF_FFFF, "R8");
        single(1, 1, 32'h2004_0000, 2'd2, 32'hFFFF_FFFF, "R8");
        single(2, 0, 32'h2003_0000, 2'd2, 0, "R8");
        single(3, 0, 32'h2000_0000, 2'd2, 0, "R8");
        drive(0, 1, 32'h4000_0000, 2'd2, 32'h1);
        drive(1, 1, 32'h5000_0000, 2'd2, 32'h1);
        step(4'b0000, "R8");
        settle("R8");

        for (int m = 0; m < NUM_M; m++)
            check(sbq[m].size() == 0, "R2", $sformatf("drained m%0d", m), sbq[m].size(), 0);

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule